// File: doc/BRIEF.md
# Boot ROM Page Selector with Recovery and Flash-Programming Modes

This block holds the 8-bit number of the 16K flash page that the core shows in its low ROM window (0x0000–0x3FFF). Software can load the whole number with one direct write, or use the two older one-bit ROM-select writes, which only replace bit 0 and bit 1 of the same register. The upper six bits keep their value, so one bank of four 16K ROM images can be picked by a single direct write and then moved through by legacy code.

A small mode state machine sits next to the register. A recovery key event swaps the flash in the ROM window for an on-chip ROM at once. If the key is pressed while reset is held, the core starts up already in that mode. A control write of a fixed key value switches to flash-programming mode. In this mode the on-chip ROM sits in the ROM window, the selected flash page is shown in the 0x8000–0xBFFF window, and CPU writes to that window reach the flash write strobe. The states are BOOT_PLAIN and BOOT_SAFE (held in reset, with or without the key seen), NORMAL, SAFE and PROG. The transitions are RELEASE (a boot state goes to NORMAL or SAFE when reset drops), KEY (NORMAL or PROG goes to SAFE), PROG_ENTER (NORMAL goes to PROG) and PROG_EXIT (PROG goes to NORMAL). SAFE is left only by reset.

Top module: `rom_page_sel`

## Requirements
- R1: A cycle with `wr_page` high loads all eight bits of `din` into `flash_page`, which shows the new value after that clock edge.
- R2: A cycle with `wr_rom0` high copies `din[4]` into bit 0 of `flash_page`. Bits 7:1 keep their value.
- R3: A cycle with `wr_rom1` high copies `din[2]` into bit 1 of `flash_page`. Bits 7:2 and bit 0 keep their value. Loading 16 and then writing 1 through both legacy paths gives 19.
- R4: When a direct write and a legacy write fall in the same cycle, the legacy bit takes priority over the direct data at its position. Two legacy writes in the same cycle update both bits.
- R5: A `safe_key` pulse in NORMAL or PROG raises `rom_internal` from the next clock edge and lowers `flash_window`.
- R6: Once safe mode is entered it holds until a reset during which `safe_key` is never seen. A `safe_key` pulse in any cycle while `rst_n` is low makes the block come out of reset in safe mode.
- R7: A `wr_mode` write with `din` = 0xFA in NORMAL enters programming mode, where `rom_internal` and `flash_window` are both 1. Any other `wr_mode` value in programming mode returns to NORMAL. `wr_mode` has no effect in safe mode.
- R8: `flash_we` is 1 only in programming mode, while `mem_wr` is 1 and `addr_hi` = 2'b10. In every other mode it stays 0.
- R9: A `safe_key` pulse and a programming-mode write in the same NORMAL cycle lead to safe mode, not programming mode.
- R10: After a reset without the key, `flash_page` is 0 and `rom_internal`, `flash_window` and `flash_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | CPU data bus for port writes |
| wr_page | input | 1 | Direct page-register write strobe |
| wr_rom0 | input | 1 | Legacy ROM-select write strobe, low bit |
| wr_rom1 | input | 1 | Legacy ROM-select write strobe, high bit |
| wr_mode | input | 1 | Mode control write strobe |
| safe_key | input | 1 | Recovery key event, one cycle |
| mem_wr | input | 1 | CPU memory write cycle |
| addr_hi | input | 2 | CPU address bits 15:14 |
| rom_internal | output | 1 | ROM window uses the on-chip ROM |
| flash_page | output | 8 | Selected flash page number |
| flash_window | output | 1 | Flash page is shown at 0x8000–0xBFFF |
| flash_we | output | 1 | Gated flash write strobe |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a direct page write together with one or both legacy bit writes. The bench drives both strobes in the same cycle with data whose bit 4 or bit 2 differs from the direct value. It then checks that the legacy bit wins at its position and that the direct data sets every other bit.

The second pair is a recovery key pulse together with the programming-mode control write. The bench drives both in one cycle. It then checks that the ROM window is internal, that the 0x8000 window stays off and that a later CPU write reaches no flash strobe.

// File: rtl/rom_page_pkg.sv
package rom_page_pkg;
    typedef enum logic [2:0] {
        M_BOOT_PLAIN = 3'd0,
        M_BOOT_SAFE  = 3'd1,
        M_NORMAL     = 3'd2,
        M_SAFE       = 3'd3,
        M_PROG       = 3'd4
    } mode_t;
endpackage

// File: rtl/rp_page_reg.sv
module rp_page_reg #(
    parameter int PAGE_W   = 8,
    parameter int LEG0_BIT = 4,
    parameter int LEG1_BIT = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] din,
    input  logic              wr_page,
    input  logic              wr_rom0,
    input  logic              wr_rom1,
    output logic [PAGE_W-1:0] page
);
    logic [PAGE_W-1:0] nxt;

    always_comb begin
        nxt = page;
        if (wr_page) nxt = din;
        if (wr_rom0) nxt[0] = din[LEG0_BIT];
        if (wr_rom1) nxt[1] = din[LEG1_BIT];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) page <= '0;
        else        page <= nxt;
    end

    // R1: full load when no legacy strobe
    p_dir_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_page && !wr_rom0 && !wr_rom1) |=> page == $past(din));
    // R2: legacy low write keeps upper bits
    p_leg0_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_rom0 && !wr_page && !wr_rom1) |=>
        (page[PAGE_W-1:1] == $past(page[PAGE_W-1:1])) && (page[0] == $past(din[LEG0_BIT])));
    // R3: legacy high write sets bit 1
    p_leg1_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_rom1 |=> page[1] == $past(din[LEG1_BIT]));
endmodule

// File: rtl/rp_mode_fsm.sv
module rp_mode_fsm
    import rom_page_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter logic [7:0]  PROG_KEY = 8'hFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] din,
    input  logic              wr_mode,
    input  logic              safe_key,
    output mode_t             mode
);
    mode_t nxt;
    logic  key_match;

    assign key_match = (din == DATA_W'(PROG_KEY));

    always_comb begin
        nxt = mode;
        unique case (mode)
            M_BOOT_PLAIN: nxt = M_NORMAL;
            M_BOOT_SAFE:  nxt = M_SAFE;
            M_NORMAL: begin
                if (safe_key)                    nxt = M_SAFE;
                else if (wr_mode && key_match)   nxt = M_PROG;
            end
            M_PROG: begin
                if (safe_key)                    nxt = M_SAFE;
                else if (wr_mode && !key_match)  nxt = M_NORMAL;
            end
            M_SAFE:  nxt = M_SAFE;
            default: nxt = M_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (safe_key)                mode <= M_BOOT_SAFE;
            else if (mode == M_BOOT_SAFE) mode <= M_BOOT_SAFE;
            else                          mode <= M_BOOT_PLAIN;
        end else begin
            mode <= nxt;
        end
    end

    // R5: key in a running mode leads to safe
    p_key_to_safe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == M_NORMAL || mode == M_PROG) && safe_key) |=> mode == M_SAFE);
    // R6: safe holds while out of reset
    p_safe_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_SAFE) |=> mode == M_SAFE);
    // R7: programming exit on a non-key control write
    p_prog_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_PROG && wr_mode && !key_match && !safe_key) |=> mode == M_NORMAL);
endmodule

// File: rtl/rp_window_map.sv
module rp_window_map
    import rom_page_pkg::*;
#(
    parameter int         WIN_W    = 2,
    parameter logic [1:0] PROG_WIN = 2'b10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             mem_wr,
    input  logic [WIN_W-1:0] addr_hi,
    output logic             rom_internal,
    output logic             flash_window,
    output logic             flash_we
);
    always_comb begin
        rom_internal = 1'b0;
        flash_window = 1'b0;
        flash_we     = 1'b0;
        unique case (mode)
            M_BOOT_SAFE, M_SAFE: rom_internal = 1'b1;
            M_PROG: begin
                rom_internal = 1'b1;
                flash_window = 1'b1;
                flash_we     = mem_wr && (addr_hi == WIN_W'(PROG_WIN));
            end
            default: ;
        endcase
    end

    // R8: a flash write strobe implies the programming window is open
    p_we_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        flash_we |-> (flash_window && rom_internal && mem_wr));
endmodule

// File: rtl/rom_page_sel.sv
module rom_page_sel #(
    parameter int         PAGE_W   = 8,
    parameter int         LEG0_BIT = 4,
    parameter int         LEG1_BIT = 2,
    parameter logic [7:0] PROG_KEY = 8'hFA,
    parameter int         WIN_W    = 2,
    parameter logic [1:0] PROG_WIN = 2'b10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] din,
    input  logic              wr_page,
    input  logic              wr_rom0,
    input  logic              wr_rom1,
    input  logic              wr_mode,
    input  logic              safe_key,
    input  logic              mem_wr,
    input  logic [WIN_W-1:0]  addr_hi,
    output logic              rom_internal,
    output logic [PAGE_W-1:0] flash_page,
    output logic              flash_window,
    output logic              flash_we
);
    import rom_page_pkg::*;

    mode_t mode;

    rp_page_reg #(.PAGE_W(PAGE_W), .LEG0_BIT(LEG0_BIT), .LEG1_BIT(LEG1_BIT)) u_page (
        .clk(clk), .rst_n(rst_n), .din(din),
        .wr_page(wr_page), .wr_rom0(wr_rom0), .wr_rom1(wr_rom1),
        .page(flash_page)
    );

    rp_mode_fsm #(.DATA_W(PAGE_W), .PROG_KEY(PROG_KEY)) u_fsm (
        .clk(clk), .rst_n(rst_n), .din(din),
        .wr_mode(wr_mode), .safe_key(safe_key), .mode(mode)
    );

    rp_window_map #(.WIN_W(WIN_W), .PROG_WIN(PROG_WIN)) u_map (
        .clk(clk), .rst_n(rst_n), .mode(mode),
        .mem_wr(mem_wr), .addr_hi(addr_hi),
        .rom_internal(rom_internal), .flash_window(flash_window), .flash_we(flash_we)
    );

    // R9: key and programming request together never open the flash window
    p_key_beats_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (safe_key && !flash_window) |=> (rom_internal && !flash_window));
endmodule

// File: tb/rom_page_sel_tb.sv
module rom_page_sel_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] din = '0;
    logic       wr_page = 0, wr_rom0 = 0, wr_rom1 = 0, wr_mode = 0, safe_key = 0, mem_wr = 0;
    logic [1:0] addr_hi = '0;
    logic       rom_internal, flash_window, flash_we;
    logic [7:0] flash_page;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rom_page_sel u_dut (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_page(wr_page), .wr_rom0(wr_rom0),
        .wr_rom1(wr_rom1), .wr_mode(wr_mode), .safe_key(safe_key), .mem_wr(mem_wr),
        .addr_hi(addr_hi), .rom_internal(rom_internal), .flash_page(flash_page),
        .flash_window(flash_window), .flash_we(flash_we)
    );

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %0d expected %0d", req, got, exp);
        end
    endtask

    // drive strobes for one clock edge, then return at the following negedge
    task automatic strobe(input logic [7:0] d, input bit p, input bit r0, input bit r1,
                          input bit m, input bit k);
        din = d; wr_page = p; wr_rom0 = r0; wr_rom1 = r1; wr_mode = m; safe_key = k;
        @(negedge clk);
        wr_page = 0; wr_rom0 = 0; wr_rom1 = 0; wr_mode = 0; safe_key = 0; din = '0;
    endtask

    task automatic apply_reset(input bit key);
        rst_n = 0;
        @(negedge clk);
        safe_key = key;
        @(negedge clk);
        safe_key = 0;
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        apply_reset(0);
        chk("R10 page", flash_page, 0);
        chk("R10 rom_internal", rom_internal, 0);
        chk("R10 flash_window", flash_window, 0);
        mem_wr = 1; addr_hi = 2'b10; #1;
        chk("R10 flash_we", flash_we, 0);
        mem_wr = 0; addr_hi = 0;
    endtask

    task automatic t_direct;
        strobe(8'hA5, 1, 0, 0, 0, 0);
        chk("R1 load A5", flash_page, 8'hA5);
        strobe(8'h3C, 1, 0, 0, 0, 0);
        chk("R1 load 3C", flash_page, 8'h3C);
    endtask

    task automatic t_legacy;
        strobe(8'h10, 0, 1, 0, 0, 0);
        chk("R2 set bit0", flash_page, 8'h3D);
        strobe(8'h04, 0, 0, 1, 0, 0);
        chk("R3 set bit1", flash_page, 8'h3F);
        strobe(8'hEF, 0, 1, 0, 0, 0);
        chk("R2 clear bit0", flash_page, 8'h3E);
        strobe(8'hFB, 0, 0, 1, 0, 0);
        chk("R3 clear bit1", flash_page, 8'h3C);
        strobe(8'd16, 1, 0, 0, 0, 0);
        strobe(8'h10, 0, 1, 0, 0, 0);
        strobe(8'h04, 0, 0, 1, 0, 0);
        chk("R3 bank example", flash_page, 19);
    endtask

    task automatic t_same_cycle;
        strobe(8'h80, 1, 1, 0, 0, 0);
        chk("R4 direct+rom0", flash_page, 8'h80);
        strobe(8'h04, 1, 0, 1, 0, 0);
        chk("R4 direct+rom1", flash_page, 8'h06);
        strobe(8'h14, 0, 1, 1, 0, 0);
        chk("R4 both legacy", flash_page, 8'h07);
    endtask

    task automatic t_prog;
        strobe(8'hFA, 0, 0, 0, 1, 0);
        chk("R7 prog rom", rom_internal, 1);
        chk("R7 prog window", flash_window, 1);
        mem_wr = 1; addr_hi = 2'b10; #1;
        chk("R8 we in window", flash_we, 1);
        addr_hi = 2'b01; #1;
        chk("R8 we outside window", flash_we, 0);
        mem_wr = 0; addr_hi = 2'b10; #1;
        chk("R8 we no write", flash_we, 0);
        strobe(8'h00, 0, 0, 0, 1, 0);
        chk("R7 exit rom", rom_internal, 0);
        chk("R7 exit window", flash_window, 0);
        mem_wr = 1; #1;
        chk("R8 we normal", flash_we, 0);
        mem_wr = 0; addr_hi = 0;
    endtask

    task automatic t_safe;
        strobe(8'h00, 0, 0, 0, 0, 1);
        chk("R5 safe rom", rom_internal, 1);
        chk("R5 safe window", flash_window, 0);
        strobe(8'hFA, 0, 0, 0, 1, 0);
        chk("R7 ignored in safe", flash_window, 0);
        mem_wr = 1; addr_hi = 2'b10; #1;
        chk("R8 we in safe", flash_we, 0);
        mem_wr = 0; addr_hi = 0;
        repeat (5) @(negedge clk);
        chk("R6 safe holds", rom_internal, 1);
        apply_reset(0);
        chk("R6 plain reset clears", rom_internal, 0);
        strobe(8'hFA, 0, 0, 0, 1, 0);
        strobe(8'h00, 0, 0, 0, 0, 1);
        chk("R5 prog to safe rom", rom_internal, 1);
        chk("R5 prog to safe window", flash_window, 0);
    endtask

    task automatic t_key_vs_prog;
        apply_reset(0);
        strobe(8'hFA, 0, 0, 0, 1, 1);
        chk("R9 rom", rom_internal, 1);
        chk("R9 window", flash_window, 0);
        mem_wr = 1; addr_hi = 2'b10; #1;
        chk("R9 we", flash_we, 0);
        mem_wr = 0; addr_hi = 0;
    endtask

    task automatic t_boot_safe;
        strobe(8'h55, 1, 0, 0, 0, 0);
        apply_reset(1);
        chk("R6 boot safe rom", rom_internal, 1);
        chk("R6 boot safe page", flash_page, 0);
        apply_reset(0);
        chk("R6 boot plain", rom_internal, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_direct();
        t_legacy();
        t_same_cycle();
        t_prog();
        t_safe();
        t_key_vs_prog();
        t_boot_safe();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog got 0 expected 1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule